// File: doc/BRIEF.md
# Write Data Beat Pacer

This block schedules the bus cycles of one processor write on a shared address/data bus. A request carries an address and either one data word or a block of words. The block puts the address on the bus in the cycle after it accepts the request. It then waits a programmed number of empty cycles. After that it places the data words on the bus, but only in the slots that the selected repeating drive/idle pattern allows.

A 4-bit rate code picks the pattern. Some patterns drive a pair of words and then leave a number of idle slots. Others drive one word and then leave one to three idle slots. Code 0 drives a word on every cycle. A 3-bit gap setting inserts 0 to 7 cycles between the address cycle and the first data slot. A strobe marks each cycle in which the bus carries a meaningful value. A busy level and a one-cycle done pulse let the requester start the next write.

Top module: `wr_beat_pacer`

## Requirements
- R1: After reset, bus_valid, busy, done and code_err are low, and bus_out is zero.
- R2: A request sampled with req_valid high while busy is low is accepted. In the next cycle bus_out carries req_addr, bus_valid is high and busy is high.
- R3: After the address cycle there are exactly gap_cfg cycles (0 to 7) with bus_valid low and bus_out still holding the address. The first pattern slot follows them.
- R4: Rate code 0 drives a data word in every slot.
- R5: Rate codes 1, 2, 4, 5 and 7 repeat a group of two driven slots followed by 1, 2, 3, 4 and 6 idle slots respectively.
- R6: Rate codes 3, 6 and 8 repeat one driven slot followed by 1, 2 and 3 idle slots respectively.
- R7: With req_block high, the write carries BLOCK_WORDS words. Word i is req_data bits [i*DW +: DW], and the words are driven in ascending order of i. With req_block low, the write carries word 0 only. The pattern starts from its first slot at every write.
- R8: In idle slots bus_valid is low and bus_out holds the last driven value.
- R9: busy falls in the cycle right after the cycle that carries the last data word. done is high for exactly that one cycle.
- R10: A request raised while busy is high is ignored. It does not change the write in progress, and it does not start a write afterwards.
- R11: Rate codes 9 to 15 pace the data like code 0. They also set code_err, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_code | input | 4 | Data-rate pattern code, sampled at acceptance |
| gap_cfg | input | GAP_W (3) | Address-to-data gap in cycles, sampled at acceptance |
| req_valid | input | 1 | Write request |
| req_block | input | 1 | 1: block write of BLOCK_WORDS words; 0: single word |
| req_addr | input | AW | Write address |
| req_data | input | BLOCK_WORDS*DW | Packed data words, word 0 in the least significant bits |
| bus_out | output | DW (AW = DW) | Multiplexed bus value |
| bus_valid | output | 1 | High on the address cycle and on data cycles |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse when busy falls |
| code_err | output | 1 | Sticky flag for a reserved rate code |

## Verification
Each of the nine valid codes drives a full block. This separates the two-word groups from the single-word groups and tells apart every idle length from 1 to 6. Single writes and gaps of 0, 3 and 7 show that the gap count and the single-word path both work, and that the pattern restarts from slot 0 between writes. A reserved code is run with a block and then followed by a valid write; this shows the fallback to every-cycle pacing and that the error flag stays set. A request raised mid-write shows that requests are locked out while busy.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
   localparam int CODE_W   = 4;
   localparam int LEN_W    = 4;
   localparam int SLOT_W   = 3;
   localparam int MAX_CODE = 8;

   typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_DATA, ST_FIN} pacer_st_e;

   // slots per pattern period
   function automatic logic [LEN_W-1:0] rate_len(input logic [CODE_W-1:0] c);
      case (c)
         4'd1:    rate_len = 4'd3;
         4'd2:    rate_len = 4'd4;
         4'd3:    rate_len = 4'd2;
         4'd4:    rate_len = 4'd5;
         4'd5:    rate_len = 4'd6;
         4'd6:    rate_len = 4'd3;
         4'd7:    rate_len = 4'd8;
         4'd8:    rate_len = 4'd4;
         default: rate_len = 4'd1;
      endcase
   endfunction

   // driven slots at the start of each period
   function automatic logic [1:0] rate_burst(input logic [CODE_W-1:0] c);
      case (c)
         4'd1, 4'd2, 4'd4, 4'd5, 4'd7: rate_burst = 2'd2;
         default:                      rate_burst = 2'd1;
      endcase
   endfunction
endpackage

// File: rtl/wbp_code_filter.sv
module wbp_code_filter
   import wbp_pkg::*;
(
   input  logic [CODE_W-1:0] code_in,
   output logic [CODE_W-1:0] code_eff,
   output logic              code_bad
);
   always_comb begin
      code_bad = (code_in > CODE_W'(MAX_CODE));
      code_eff = code_bad ? '0 : code_in;
   end
endmodule

// File: rtl/wbp_slot_gen.sv
module wbp_slot_gen
   import wbp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              advance,
   input  logic [CODE_W-1:0] code,
   output logic              drive
);
   logic [SLOT_W-1:0] slot_q;
   logic [LEN_W-1:0]  len;
   logic [1:0]        burst;

   always_comb begin
      len   = rate_len(code);
      burst = rate_burst(code);
      drive = ({1'b0, slot_q} < {2'b00, burst});
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         slot_q <= '0;
      end else if (advance) begin
         if ({1'b0, slot_q} + LEN_W'(1) == len) slot_q <= '0;
         else                                   slot_q <= slot_q + 1'b1;
      end
   end
endmodule

// File: rtl/wr_beat_pacer.sv
module wr_beat_pacer
   import wbp_pkg::*;
#(
   parameter int DW          = 32,
   parameter int AW          = 32,
   parameter int BLOCK_WORDS = 4,
   parameter int GAP_W       = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [CODE_W-1:0]         rate_code,
   input  logic [GAP_W-1:0]          gap_cfg,
   input  logic                      req_valid,
   input  logic                      req_block,
   input  logic [AW-1:0]             req_addr,
   input  logic [BLOCK_WORDS*DW-1:0] req_data,
   output logic [DW-1:0]             bus_out,
   output logic                      bus_valid,
   output logic                      busy,
   output logic                      done,
   output logic                      code_err
);
   localparam int IDX_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;

   if (BLOCK_WORDS < 2) begin : g_bad_words
      $error("BLOCK_WORDS must be at least 2");
   end
   if (AW != DW) begin : g_bad_width
      $error("address and data share the bus: AW must equal DW");
   end
   if (GAP_W < 1) begin : g_bad_gap
      $error("GAP_W must be at least 1");
   end

   pacer_st_e          st_q;
   logic [GAP_W-1:0]   gcnt_q;
   logic [IDX_W-1:0]   widx_q, last_q;
   logic [CODE_W-1:0]  code_q, code_eff;
   logic               code_bad, drive, accept;
   logic [DW-1:0]      words_q [BLOCK_WORDS];
   logic [DW-1:0]      bus_q;
   logic               vld_q, busy_q, done_q, err_q;

   assign accept = (st_q == ST_IDLE) && req_valid;

   wbp_code_filter u_filter (
      .code_in  (rate_code),
      .code_eff (code_eff),
      .code_bad (code_bad)
   );

   wbp_slot_gen u_slots (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .advance (st_q == ST_DATA),
      .code    (code_q),
      .drive   (drive)
   );

   for (genvar i = 0; i < BLOCK_WORDS; i++) begin : g_words
      always_ff @(posedge clk) begin
         if (!rst_n)      words_q[i] <= '0;
         else if (accept) words_q[i] <= req_data[i*DW +: DW];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         gcnt_q <= '0;
         widx_q <= '0;
         last_q <= '0;
         code_q <= '0;
         bus_q  <= '0;
         vld_q  <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  bus_q  <= req_addr;
                  vld_q  <= 1'b1;
                  busy_q <= 1'b1;
                  code_q <= code_eff;
                  gcnt_q <= gap_cfg;
                  widx_q <= '0;
                  last_q <= req_block ? IDX_W'(BLOCK_WORDS - 1) : '0;
                  st_q   <= (gap_cfg == '0) ? ST_DATA : ST_GAP;
                  if (code_bad) err_q <= 1'b1;
               end
            end
            ST_GAP: begin
               vld_q  <= 1'b0;
               gcnt_q <= gcnt_q - 1'b1;
               if (gcnt_q == GAP_W'(1)) st_q <= ST_DATA;
            end
            ST_DATA: begin
               if (drive) begin
                  bus_q  <= words_q[widx_q];
                  vld_q  <= 1'b1;
                  widx_q <= widx_q + 1'b1;
                  if (widx_q == last_q) st_q <= ST_FIN;
               end else begin
                  vld_q <= 1'b0;
               end
            end
            default: begin
               vld_q  <= 1'b0;
               busy_q <= 1'b0;
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
         endcase
      end
   end

   assign bus_out   = bus_q;
   assign bus_valid = vld_q;
   assign busy      = busy_q;
   assign done      = done_q;
   assign code_err  = err_q;
endmodule

// File: rtl/wr_beat_pacer_chk.sv
module wr_beat_pacer_chk #(
   parameter int DW = 32,
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic [3:0]    rate_code,
   input logic          req_valid,
   input logic [AW-1:0] req_addr,
   input logic [DW-1:0] bus_out,
   input logic          bus_valid,
   input logic          busy,
   input logic          done,
   input logic          code_err
);
   a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> (bus_valid && busy && bus_out == $past(req_addr)));

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_valid && busy) |-> $stable(bus_out));

   a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && $past(bus_valid)));

   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      code_err |=> code_err);

   a_r11_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && rate_code > 4'd8) |=> code_err);
endmodule

bind wr_beat_pacer wr_beat_pacer_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rate_code (rate_code),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .bus_out   (bus_out),
   .bus_valid (bus_valid),
   .busy      (busy),
   .done      (done),
   .code_err  (code_err)
);

// File: tb/wr_beat_pacer_tb_top.sv
`timescale 1ns/1ps
module wr_beat_pacer_tb_top;
   localparam int DW = 32;
   localparam int NW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    rate_code = '0;
   logic [2:0]    gap_cfg = '0;
   logic          req_valid = 1'b0;
   logic          req_block = 1'b0;
   logic [DW-1:0] req_addr = '0;
   logic [NW*DW-1:0] req_data = '0;
   logic [DW-1:0] bus_out;
   logic          bus_valid, busy, done, code_err;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   wr_beat_pacer #(.DW(DW), .AW(DW), .BLOCK_WORDS(NW), .GAP_W(3)) dut_i (
      .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .gap_cfg(gap_cfg),
      .req_valid(req_valid), .req_block(req_block), .req_addr(req_addr),
      .req_data(req_data), .bus_out(bus_out), .bus_valid(bus_valid),
      .busy(busy), .done(done), .code_err(code_err)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_len(input int c);
      case (c)
         1: return 3; 2: return 4; 3: return 2; 4: return 5;
         5: return 6; 6: return 3; 7: return 8; 8: return 4;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_burst(input int c);
      if (c == 1 || c == 2 || c == 4 || c == 5 || c == 7) return 2;
      return 1;
   endfunction

   function automatic logic [DW-1:0] word_of(input logic [DW-1:0] a, input int i);
      return a ^ (32'h1357_9BDF + 32'(i) * 32'h0101_0101);
   endfunction

   // One write: drive the request, then follow the bus cycle by cycle.
   task automatic run_write(input string req, input int code, input int gap,
                            input bit blk, input logic [DW-1:0] addr, input bit poke);
      int eff, len, nd, nw, s, w;
      logic [DW-1:0] last;
      eff = (code > 8) ? 0 : code;
      len = exp_len(eff);
      nd  = exp_burst(eff);
      nw  = blk ? NW : 1;
      @(negedge clk);
      rate_code = 4'(code); gap_cfg = 3'(gap); req_block = blk; req_addr = addr;
      for (int i = 0; i < NW; i++) req_data[i*DW +: DW] = word_of(addr, i);
      req_valid = 1'b1;
      @(negedge clk);
      // R2 address cycle
      check({req, " R2 valid"}, 64'(bus_valid), 64'd1);
      check({req, " R2 addr"},  64'(bus_out), 64'(addr));
      check({req, " R2 busy"},  64'(busy), 64'd1);
      if (poke) begin
         // R10: hold request high with other values while busy
         req_addr = ~addr; rate_code = 4'd7; gap_cfg = 3'd5;
      end else begin
         req_valid = 1'b0;
      end
      last = addr;
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         check({req, " R3 gap valid"}, 64'(bus_valid), 64'd0);
         check({req, " R3 gap hold"},  64'(bus_out), 64'(addr));
         if (poke && g == 0) req_valid = 1'b0;
      end
      s = 0; w = 0;
      while (w < nw) begin
         @(negedge clk);
         if (poke) req_valid = 1'b0;
         check({req, " R9 busy"}, 64'(busy), 64'd1);
         if (s < nd) begin
            check({req, " R4 R5 R6 R7 drive"}, 64'(bus_valid), 64'd1);
            check({req, " R7 word"}, 64'(bus_out), 64'(word_of(addr, w)));
            last = word_of(addr, w);
            w++;
         end else begin
            check({req, " R8 idle valid"}, 64'(bus_valid), 64'd0);
            check({req, " R8 idle hold"},  64'(bus_out), 64'(last));
         end
         s = (s + 1) % len;
      end
      @(negedge clk);
      check({req, " R9 busy low"}, 64'(busy), 64'd0);
      check({req, " R9 done"},     64'(done), 64'd1);
      check({req, " R9 valid"},    64'(bus_valid), 64'd0);
      @(negedge clk);
      check({req, " R9 done drop"},     64'(done), 64'd0);
      check({req, " R10 no new write"}, 64'(bus_valid), 64'd0);
      check({req, " R10 idle busy"},    64'(busy), 64'd0);
   endtask

   task automatic t_reset();
      check("R1 valid", 64'(bus_valid), 64'd0);
      check("R1 busy",  64'(busy), 64'd0);
      check("R1 done",  64'(done), 64'd0);
      check("R1 err",   64'(code_err), 64'd0);
      check("R1 bus",   64'(bus_out), 64'd0);
   endtask

   task automatic t_all_codes();
      for (int c = 0; c <= 8; c++)
         run_write("R4 R5 R6 codes", c, c % 3, 1'b1, 32'hA000_0000 + 32'(c), 1'b0);
      check("R11 no err on valid codes", 64'(code_err), 64'd0);
   endtask

   task automatic t_single_and_gap();
      run_write("R7 single", 0, 3, 1'b0, 32'h0000_1234, 1'b0);
      run_write("R3 gap7",   5, 7, 1'b1, 32'h0000_5678, 1'b0);
      run_write("R7 restart single", 7, 0, 1'b0, 32'h0000_9ABC, 1'b0);
      run_write("R7 restart block",  1, 0, 1'b1, 32'h0000_DEF0, 1'b0);
   endtask

   task automatic t_busy_lockout();
      run_write("R10 poke", 2, 2, 1'b1, 32'h5555_AAAA, 1'b1);
   endtask

   task automatic t_reserved();
      run_write("R11 reserved", 12, 1, 1'b1, 32'hC0DE_0001, 1'b0);
      check("R11 err set", 64'(code_err), 64'd1);
      run_write("R11 after", 6, 0, 1'b1, 32'hC0DE_0002, 1'b0);
      check("R11 err sticky", 64'(code_err), 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_all_codes();
      t_single_and_gap();
      t_busy_lockout();
      t_reserved();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule